// File: doc/BRIEF.md
# Supervisor Trap Delegation Unit

This unit controls privilege transitions on trap entry and trap return for a core with three privilege levels: machine (encoding 3), supervisor (encoding 1) and user (encoding 0). When the pipeline raises a trap, it presents a cause index, an interrupt flag, the faulting PC and a trap value. The unit then decides which level runs the handler. It updates that level's exception PC, cause and trap-value registers and the status bits, moves the current privilege, and issues a redirect PC one cycle later. It also executes the two trap-return instructions, which restore the privilege and interrupt-enable state saved at entry.

A small CSR port gives software access to the status word, the two delegation masks (one for exceptions, one for interrupts), and the vector, exception-PC, cause and trap-value registers of both levels. The supervisor status view has no storage of its own. It is a masked window onto three bits of the machine status word, so both addresses always agree.

Top module: `trap_deleg_unit`

## Requirements
- R1: After reset the privilege is machine (3), the machine status word, both delegation masks and all CSRs read zero, and no redirect is issued.
- R2: A trap goes to the supervisor level exactly when the current privilege is not machine and the mask bit at the cause index is set. The exception mask (address 0x302) is used when the interrupt flag is low, and the interrupt mask (0x303) when it is high. Every other trap goes to the machine level.
- R3: A supervisor-level trap writes the PC to 0x141, the cause word to 0x142 and the trap value to 0x143. It sets SPP (status bit 8) to 1 if the old privilege was supervisor and 0 if it was user, copies SIE (bit 1) into SPIE (bit 5), clears SIE, sets the privilege to supervisor and redirects to the 0x105 vector with its two low bits forced to zero.
- R4: A machine-level trap writes the PC to 0x341, the cause word to 0x342 and the trap value to 0x343. It copies the old privilege into MPP (bits 12:11), copies MIE (bit 3) into MPIE (bit 7), clears MIE, sets the privilege to machine and redirects to the 0x305 vector with its two low bits forced to zero.
- R5: The cause word holds the interrupt flag in bit 31 and the cause index in its low bits, with zeros in between.
- R6: The 32-bit word 0x10200073 is the supervisor return. It sets the privilege to supervisor if SPP is 1 and to user otherwise, copies SPIE into SIE, sets SPIE to 1, clears SPP and redirects to the value at 0x141.
- R7: The 32-bit word 0x30200073 is the machine return. It sets the privilege from MPP, copies MPIE into MIE, sets MPIE to 1, sets MPP to user and redirects to the value at 0x341.
- R8: A return strobe carrying any other instruction word has no effect: no redirect, no privilege change and no status change.
- R9: Reading the supervisor status address 0x100 returns the machine status word (0x300) masked to bits 1, 5 and 8. All other bits read zero.
- R10: Writing 0x100 changes only bits 1, 5 and 8 of the machine status word. Writing 0x300 sets bits 1, 3, 5, 7, 8 and 12:11 and ignores all other bits. An MPP value of 2 is stored as 0.
- R11: Within one cycle a trap takes priority over a return, and a return takes priority over a CSR write. The lower-priority request is dropped.
- R12: The ten word registers at 0x302, 0x303, 0x305, 0x105, 0x341, 0x141, 0x342, 0x142, 0x343 and 0x143 read back exactly what was written. Any unlisted address reads zero.
- R13: The redirect strobe is high for exactly the one cycle after an accepted trap or return, together with its target PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| trapValid | input | 1 | Trap request this cycle |
| trapIsIrq | input | 1 | Request is an interrupt (else exception) |
| trapCause | input | CAUSE_W | Cause index |
| trapPc | input | XLEN | PC of the trapping instruction |
| trapVal | input | XLEN | Trap value |
| retValid | input | 1 | A return candidate is presented |
| retInsn | input | 32 | Instruction word of the candidate |
| csrWe | input | 1 | CSR write strobe |
| csrAddr | input | 12 | CSR address for read and write |
| csrWdata | input | XLEN | CSR write data |
| csrRdata | output | XLEN | Combinational CSR read data |
| curPriv | output | 2 | Current privilege level |
| redirectValid | output | 1 | Redirect request |
| redirectPc | output | XLEN | Redirect target |

## Verification
The hardest case to reach from the ports is a trap that arrives while the core already sits in user or supervisor mode, with a chosen set of enable bits. Reset always leaves the core in machine mode. The bench therefore drives every trap through a set-up sequence: it writes the saved-privilege and saved-enable fields of the status word, issues a machine return to drop into the target level, and then writes the supervisor enable bit. Over all three levels, both trap kinds, every cause index and both mask polarities, it loads the unused mask with the complement of the tested mask. A lookup in the wrong mask or at the wrong bit therefore gives a visibly wrong routing.

// File: rtl/td_pkg.sv
package td_pkg;
  localparam logic [1:0] PRIV_U = 2'b00;
  localparam logic [1:0] PRIV_S = 2'b01;
  localparam logic [1:0] PRIV_M = 2'b11;

  localparam logic [31:0] OPC_SRET = 32'h1020_0073;
  localparam logic [31:0] OPC_MRET = 32'h3020_0073;

  localparam logic [11:0] A_MSTATUS = 12'h300;
  localparam logic [11:0] A_SSTATUS = 12'h100;
  localparam logic [11:0] A_EDELEG  = 12'h302;
  localparam logic [11:0] A_IDELEG  = 12'h303;

  localparam logic [7:0] OFS_TVEC  = 8'h05;
  localparam logic [7:0] OFS_EPC   = 8'h41;
  localparam logic [7:0] OFS_CAUSE = 8'h42;
  localparam logic [7:0] OFS_TVAL  = 8'h43;

  localparam int B_SIE   = 1;
  localparam int B_MIE   = 3;
  localparam int B_SPIE  = 5;
  localparam int B_MPIE  = 7;
  localparam int B_SPP   = 8;
  localparam int B_MPPLO = 11;

  typedef struct packed {
    logic trapToS;
    logic trapToM;
    logic doSret;
    logic doMret;
    logic csrWr;
  } strobeT;
endpackage

// File: rtl/td_ctrl.sv
module td_ctrl
  import td_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 5
) (
  input  logic               trapValid,
  input  logic               trapIsIrq,
  input  logic [CAUSE_W-1:0] trapCause,
  input  logic               retValid,
  input  logic [31:0]        retInsn,
  input  logic               csrWe,
  input  logic [XLEN-1:0]    edeleg,
  input  logic [XLEN-1:0]    ideleg,
  input  logic [1:0]         curPriv,
  output strobeT             strobe
);
  logic maskBit;
  logic delegOk;
  logic isSret;
  logic isMret;

  always_comb begin
    maskBit = trapIsIrq ? ideleg[trapCause] : edeleg[trapCause];
    delegOk = (curPriv != PRIV_M) && maskBit;
    isSret  = retValid && (retInsn == OPC_SRET);
    isMret  = retValid && (retInsn == OPC_MRET);

    strobe.trapToS = trapValid && delegOk;
    strobe.trapToM = trapValid && !delegOk;
    strobe.doSret  = !trapValid && isSret;
    strobe.doMret  = !trapValid && isMret;
    strobe.csrWr   = csrWe && !trapValid && !isSret && !isMret;
  end
endmodule

// File: rtl/td_lvlregs.sv
module td_lvlregs #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            capture,
  input  logic [XLEN-1:0] capPc,
  input  logic [XLEN-1:0] capCause,
  input  logic [XLEN-1:0] capVal,
  input  logic [XLEN-1:0] wdata,
  input  logic            wrTvec,
  input  logic            wrEpc,
  input  logic            wrCause,
  input  logic            wrTval,
  output logic [XLEN-1:0] tvec,
  output logic [XLEN-1:0] epc,
  output logic [XLEN-1:0] cause,
  output logic [XLEN-1:0] tval
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      tvec  <= '0;
      epc   <= '0;
      cause <= '0;
      tval  <= '0;
    end else if (capture) begin
      epc   <= capPc;
      cause <= capCause;
      tval  <= capVal;
    end else begin
      if (wrTvec)  tvec  <= wdata;
      if (wrEpc)   epc   <= wdata;
      if (wrCause) cause <= wdata;
      if (wrTval)  tval  <= wdata;
    end
  end
endmodule

// File: rtl/td_dp.sv
module td_dp
  import td_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobeT             strobe,
  input  logic               trapIsIrq,
  input  logic [CAUSE_W-1:0] trapCause,
  input  logic [XLEN-1:0]    trapPc,
  input  logic [XLEN-1:0]    trapVal,
  input  logic [11:0]        csrAddr,
  input  logic [XLEN-1:0]    csrWdata,
  output logic [XLEN-1:0]    csrRdata,
  output logic [XLEN-1:0]    edeleg,
  output logic [XLEN-1:0]    ideleg,
  output logic [1:0]         curPriv,
  output logic               redirectValid,
  output logic [XLEN-1:0]    redirectPc
);
  localparam int NLVL = 2;  // index 0: supervisor, 1: machine
  localparam int PADW = XLEN - 1 - CAUSE_W;
  localparam logic [XLEN-1:0] SVIEW =
    XLEN'((1 << B_SIE) | (1 << B_SPIE) | (1 << B_SPP));

  logic       mie, mpie, sie, spie, spp;
  logic [1:0] mpp;
  logic [XLEN-1:0] mstatusWord;
  logic [XLEN-1:0] causeWord;
  logic [1:0]      mppIn;

  logic [XLEN-1:0] tvecQ  [NLVL];
  logic [XLEN-1:0] epcQ   [NLVL];
  logic [XLEN-1:0] causeQ [NLVL];
  logic [XLEN-1:0] tvalQ  [NLVL];

  assign causeWord = {trapIsIrq, {PADW{1'b0}}, trapCause};
  assign mppIn = (csrWdata[B_MPPLO+:2] == 2'b10) ? PRIV_U : csrWdata[B_MPPLO+:2];

  for (genvar gi = 0; gi < NLVL; gi++) begin : g_lvl
    localparam logic [3:0] HI = (gi == 1) ? 4'h3 : 4'h1;
    logic cap;
    assign cap = (gi == 1) ? strobe.trapToM : strobe.trapToS;
    td_lvlregs #(.XLEN(XLEN)) u_regs (
      .clk     (clk),
      .rstN    (rstN),
      .capture (cap),
      .capPc   (trapPc),
      .capCause(causeWord),
      .capVal  (trapVal),
      .wdata   (csrWdata),
      .wrTvec  (strobe.csrWr && (csrAddr == {HI, OFS_TVEC})),
      .wrEpc   (strobe.csrWr && (csrAddr == {HI, OFS_EPC})),
      .wrCause (strobe.csrWr && (csrAddr == {HI, OFS_CAUSE})),
      .wrTval  (strobe.csrWr && (csrAddr == {HI, OFS_TVAL})),
      .tvec    (tvecQ[gi]),
      .epc     (epcQ[gi]),
      .cause   (causeQ[gi]),
      .tval    (tvalQ[gi])
    );
  end

  always_comb begin
    mstatusWord = '0;
    mstatusWord[B_SIE]      = sie;
    mstatusWord[B_MIE]      = mie;
    mstatusWord[B_SPIE]     = spie;
    mstatusWord[B_MPIE]     = mpie;
    mstatusWord[B_SPP]      = spp;
    mstatusWord[B_MPPLO+:2] = mpp;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curPriv <= PRIV_M;
      mie  <= 1'b0;
      mpie <= 1'b0;
      mpp  <= PRIV_U;
      sie  <= 1'b0;
      spie <= 1'b0;
      spp  <= 1'b0;
      edeleg <= '0;
      ideleg <= '0;
    end else if (strobe.trapToS) begin
      spp     <= (curPriv == PRIV_S);
      spie    <= sie;
      sie     <= 1'b0;
      curPriv <= PRIV_S;
    end else if (strobe.trapToM) begin
      mpp     <= curPriv;
      mpie    <= mie;
      mie     <= 1'b0;
      curPriv <= PRIV_M;
    end else if (strobe.doSret) begin
      curPriv <= spp ? PRIV_S : PRIV_U;
      sie     <= spie;
      spie    <= 1'b1;
      spp     <= 1'b0;
    end else if (strobe.doMret) begin
      curPriv <= mpp;
      mie     <= mpie;
      mpie    <= 1'b1;
      mpp     <= PRIV_U;
    end else if (strobe.csrWr) begin
      case (csrAddr)
        A_MSTATUS: begin
          sie  <= csrWdata[B_SIE];
          mie  <= csrWdata[B_MIE];
          spie <= csrWdata[B_SPIE];
          mpie <= csrWdata[B_MPIE];
          spp  <= csrWdata[B_SPP];
          mpp  <= mppIn;
        end
        A_SSTATUS: begin
          sie  <= csrWdata[B_SIE];
          spie <= csrWdata[B_SPIE];
          spp  <= csrWdata[B_SPP];
        end
        A_EDELEG: edeleg <= csrWdata;
        A_IDELEG: ideleg <= csrWdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      redirectValid <= 1'b0;
      redirectPc    <= '0;
    end else begin
      redirectValid <= strobe.trapToS || strobe.trapToM || strobe.doSret || strobe.doMret;
      if (strobe.trapToS)      redirectPc <= {tvecQ[0][XLEN-1:2], 2'b00};
      else if (strobe.trapToM) redirectPc <= {tvecQ[1][XLEN-1:2], 2'b00};
      else if (strobe.doSret)  redirectPc <= epcQ[0];
      else if (strobe.doMret)  redirectPc <= epcQ[1];
    end
  end

  always_comb begin
    case (csrAddr)
      A_MSTATUS:                 csrRdata = mstatusWord;
      A_SSTATUS:                 csrRdata = mstatusWord & SVIEW;
      A_EDELEG:                  csrRdata = edeleg;
      A_IDELEG:                  csrRdata = ideleg;
      {4'h3, OFS_TVEC}:          csrRdata = tvecQ[1];
      {4'h1, OFS_TVEC}:          csrRdata = tvecQ[0];
      {4'h3, OFS_EPC}:           csrRdata = epcQ[1];
      {4'h1, OFS_EPC}:           csrRdata = epcQ[0];
      {4'h3, OFS_CAUSE}:         csrRdata = causeQ[1];
      {4'h1, OFS_CAUSE}:         csrRdata = causeQ[0];
      {4'h3, OFS_TVAL}:          csrRdata = tvalQ[1];
      {4'h1, OFS_TVAL}:          csrRdata = tvalQ[0];
      default:                   csrRdata = '0;
    endcase
  end
endmodule

// File: rtl/trap_deleg_unit.sv
module trap_deleg_unit
  import td_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = $clog2(XLEN)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               trapValid,
  input  logic               trapIsIrq,
  input  logic [CAUSE_W-1:0] trapCause,
  input  logic [XLEN-1:0]    trapPc,
  input  logic [XLEN-1:0]    trapVal,
  input  logic               retValid,
  input  logic [31:0]        retInsn,
  input  logic               csrWe,
  input  logic [11:0]        csrAddr,
  input  logic [XLEN-1:0]    csrWdata,
  output logic [XLEN-1:0]    csrRdata,
  output logic [1:0]         curPriv,
  output logic               redirectValid,
  output logic [XLEN-1:0]    redirectPc
);
  strobeT          strobe;
  logic [XLEN-1:0] edelegW;
  logic [XLEN-1:0] idelegW;

  td_ctrl #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_ctrl (
    .trapValid(trapValid),
    .trapIsIrq(trapIsIrq),
    .trapCause(trapCause),
    .retValid (retValid),
    .retInsn  (retInsn),
    .csrWe    (csrWe),
    .edeleg   (edelegW),
    .ideleg   (idelegW),
    .curPriv  (curPriv),
    .strobe   (strobe)
  );

  td_dp #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .trapIsIrq    (trapIsIrq),
    .trapCause    (trapCause),
    .trapPc       (trapPc),
    .trapVal      (trapVal),
    .csrAddr      (csrAddr),
    .csrWdata     (csrWdata),
    .csrRdata     (csrRdata),
    .edeleg       (edelegW),
    .ideleg       (idelegW),
    .curPriv      (curPriv),
    .redirectValid(redirectValid),
    .redirectPc   (redirectPc)
  );
endmodule

// File: rtl/td_chk.sv
module td_chk
  import td_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 5
) (
  input logic               clk,
  input logic               rstN,
  input logic               trapValid,
  input logic               trapIsIrq,
  input logic [CAUSE_W-1:0] trapCause,
  input logic               retValid,
  input logic [31:0]        retInsn,
  input logic [1:0]         curPriv,
  input logic               redirectValid,
  input logic [XLEN-1:0]    redirectPc,
  input logic [XLEN-1:0]    edeleg,
  input logic [XLEN-1:0]    ideleg
);
  assert_deleg_to_s_R2: assert property (@(posedge clk) disable iff (!rstN)
    (trapValid && curPriv != PRIV_M &&
     (trapIsIrq ? ideleg[trapCause] : edeleg[trapCause]))
    |=> (curPriv == PRIV_S && redirectValid));

  assert_mmode_holds_R2: assert property (@(posedge clk) disable iff (!rstN)
    (trapValid && curPriv == PRIV_M) |=> (curPriv == PRIV_M));

  assert_vec_aligned_R3: assert property (@(posedge clk) disable iff (!rstN)
    trapValid |=> (redirectPc[1:0] == 2'b00));

  assert_sret_leaves_m_R6: assert property (@(posedge clk) disable iff (!rstN)
    (retValid && retInsn == OPC_SRET && !trapValid)
    |=> (curPriv != PRIV_M && redirectValid));

  assert_no_stray_redirect_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!trapValid && !(retValid && (retInsn == OPC_SRET || retInsn == OPC_MRET)))
    |=> !redirectValid);

  assert_redirect_cause_R13: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |-> $past(trapValid || retValid));

  assert_legal_priv_R10: assert property (@(posedge clk) disable iff (!rstN)
    curPriv != 2'b10);
endmodule

bind trap_deleg_unit td_chk #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .trapValid    (trapValid),
  .trapIsIrq    (trapIsIrq),
  .trapCause    (trapCause),
  .retValid     (retValid),
  .retInsn      (retInsn),
  .curPriv      (curPriv),
  .redirectValid(redirectValid),
  .redirectPc   (redirectPc),
  .edeleg       (edelegW),
  .ideleg       (idelegW)
);

// File: tb/trap_deleg_unit_tb.sv
module trap_deleg_unit_tb;
  localparam logic [31:0] SRET = 32'h1020_0073;
  localparam logic [31:0] MRET = 32'h3020_0073;
  localparam logic [31:0] SVEC = 32'h8000_0103;
  localparam logic [31:0] MVEC = 32'h4000_0202;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        trapValid = 1'b0, trapIsIrq = 1'b0;
  logic [4:0]  trapCause = '0;
  logic [31:0] trapPc = '0, trapVal = '0;
  logic        retValid = 1'b0;
  logic [31:0] retInsn = '0;
  logic        csrWe = 1'b0;
  logic [11:0] csrAddr = '0;
  logic [31:0] csrWdata = '0;
  logic [31:0] csrRdata;
  logic [1:0]  curPriv;
  logic        redirectValid;
  logic [31:0] redirectPc;

  int nChecks = 0;
  int nFail = 0;
  logic        gotV, gotV2;
  logic [31:0] gotPc;
  logic [1:0]  gotPriv;

  always #4 clk = ~clk;

  trap_deleg_unit u_dut (
    .clk(clk), .rstN(rstN), .trapValid(trapValid), .trapIsIrq(trapIsIrq),
    .trapCause(trapCause), .trapPc(trapPc), .trapVal(trapVal),
    .retValid(retValid), .retInsn(retInsn), .csrWe(csrWe), .csrAddr(csrAddr),
    .csrWdata(csrWdata), .csrRdata(csrRdata), .curPriv(curPriv),
    .redirectValid(redirectValid), .redirectPc(redirectPc)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] ms(input logic mie, input logic mpie, input logic [1:0] mpp,
                                     input logic sie, input logic spie, input logic spp);
    return (32'(sie) << 1) | (32'(mie) << 3) | (32'(spie) << 5) |
           (32'(mpie) << 7) | (32'(spp) << 8) | (32'(mpp) << 11);
  endfunction

  task automatic csrW(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    csrWe = 1'b1; csrAddr = a; csrWdata = d;
    @(negedge clk);
    csrWe = 1'b0;
  endtask

  task automatic csrR(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    csrAddr = a;
    #1 d = csrRdata;
  endtask

  task automatic sample();
    gotV = redirectValid; gotPc = redirectPc; gotPriv = curPriv;
    @(negedge clk);
    gotV2 = redirectValid;
  endtask

  task automatic doRet(input logic [31:0] insn);
    @(negedge clk);
    retValid = 1'b1; retInsn = insn;
    @(negedge clk);
    retValid = 1'b0;
    sample();
  endtask

  task automatic doTrap(input logic irq, input logic [4:0] c, input logic [31:0] pc, input logic [31:0] v);
    @(negedge clk);
    trapValid = 1'b1; trapIsIrq = irq; trapCause = c; trapPc = pc; trapVal = v;
    @(negedge clk);
    trapValid = 1'b0;
    sample();
  endtask

  task automatic setPriv(input logic [1:0] p, input logic mieWant);
    csrW(12'h300, ms(1'b0, mieWant, p, 1'b0, 1'b0, 1'b0));
    doRet(MRET);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog got=%h exp=%h", 32'd0, 32'd1);
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [31:0] rd, rd2;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk("R1 priv", 32'(curPriv), 32'd3);
    chk("R1 redirect", 32'(redirectValid), 32'd0);
    csrR(12'h300, rd); chk("R1 mstatus", rd, 32'd0);
    csrR(12'h302, rd); chk("R1 edeleg", rd, 32'd0);
    csrR(12'h303, rd); chk("R1 ideleg", rd, 32'd0);
    csrR(12'h141, rd); chk("R1 sepc", rd, 32'd0);

    // R12 readback of word registers and unknown addresses
    foreach (u_addrs[i]) begin
      logic [31:0] pat;
      pat = {u_addrs[i], u_addrs[i][7:0], 12'h5A3};
      csrW(u_addrs[i], pat);
      csrR(u_addrs[i], rd);
      chk("R12 readback", rd, pat);
    end
    csrR(12'h7C0, rd); chk("R12 unknown", rd, 32'd0);
    csrR(12'h301, rd); chk("R12 unknown", rd, 32'd0);

    // R2 R3 R4 R5 R13 sweep over privilege, kind, cause and mask polarity
    csrW(12'h105, SVEC);
    csrW(12'h305, MVEC);
    for (int pi = 0; pi < 3; pi++) begin
      for (int irq = 0; irq < 2; irq++) begin
        for (int c = 0; c < 32; c++) begin
          for (int b = 0; b < 2; b++) begin
            logic [1:0]  p;
            logic [31:0] mask, pc, v, expCause;
            logic        deleg, m0, s1;
            p = (pi == 0) ? 2'd0 : (pi == 1) ? 2'd1 : 2'd3;
            mask = b ? (32'd1 << c) : ~(32'd1 << c);
            csrW(12'h302, irq ? ~mask : mask);
            csrW(12'h303, irq ? mask : ~mask);
            m0 = c[0]; s1 = c[1];
            setPriv(p, m0);
            csrW(12'h100, 32'(s1) << 1);
            chk("R7 setup priv", 32'(curPriv), 32'(p));
            deleg = (p != 2'd3) && (b == 1);
            csrW(deleg ? 12'h342 : 12'h142, 32'hDEAD_0000);
            pc = 32'h1000_0000 | (32'(c) << 8) | (32'(irq) << 4) | (32'(b) << 2) | 32'(pi);
            v = ~pc;
            expCause = (32'(irq) << 31) | 32'(c);
            doTrap(irq[0], c[4:0], pc, v);
            chk("R13 redirect valid", 32'(gotV), 32'd1);
            chk("R13 redirect one cycle", 32'(gotV2), 32'd0);
            if (deleg) begin
              chk("R2 R3 priv", 32'(gotPriv), 32'd1);
              chk("R3 target", gotPc, SVEC & ~32'd3);
              csrR(12'h141, rd); chk("R3 sepc", rd, pc);
              csrR(12'h142, rd); chk("R5 scause", rd, expCause);
              csrR(12'h143, rd); chk("R3 stval", rd, v);
              csrR(12'h342, rd); chk("R3 mcause untouched", rd, 32'hDEAD_0000);
              csrR(12'h300, rd);
              chk("R3 status", rd, ms(m0, 1'b1, 2'd0, 1'b0, s1, p == 2'd1));
            end else begin
              chk("R2 R4 priv", 32'(gotPriv), 32'd3);
              chk("R4 target", gotPc, MVEC & ~32'd3);
              csrR(12'h341, rd); chk("R4 mepc", rd, pc);
              csrR(12'h342, rd); chk("R5 mcause", rd, expCause);
              csrR(12'h343, rd); chk("R4 mtval", rd, v);
              csrR(12'h142, rd); chk("R4 scause untouched", rd, 32'hDEAD_0000);
              csrR(12'h300, rd);
              chk("R4 status", rd, ms(1'b0, m0, p, s1, 1'b0, 1'b0));
            end
          end
        end
      end
    end

    // R6 supervisor return
    for (int spp = 0; spp < 2; spp++) begin
      for (int spie = 0; spie < 2; spie++) begin
        logic [31:0] tgt;
        tgt = 32'h3000_0001 + 32'(spp * 64 + spie * 16);
        csrW(12'h141, tgt);
        csrW(12'h300, ms(1'b1, 1'b0, 2'd3, ~spie[0], spie[0], spp[0]));
        doRet(SRET);
        chk("R6 valid", 32'(gotV), 32'd1);
        chk("R6 target", gotPc, tgt);
        chk("R6 priv", 32'(gotPriv), spp ? 32'd1 : 32'd0);
        csrR(12'h300, rd);
        chk("R6 status", rd, ms(1'b1, 1'b0, 2'd3, spie[0], 1'b1, 1'b0));
      end
    end

    // R7 machine return, R10 MPP value 2 stored as 0
    for (int mpp = 0; mpp < 4; mpp++) begin
      for (int mpie = 0; mpie < 2; mpie++) begin
        logic [31:0] tgt;
        logic [1:0]  ep;
        tgt = 32'h5000_0002 + 32'(mpp * 256 + mpie * 32);
        ep = (mpp == 2) ? 2'd0 : 2'(mpp);
        csrW(12'h341, tgt);
        csrW(12'h300, ms(~mpie[0], mpie[0], 2'(mpp), 1'b1, 1'b0, 1'b1));
        csrR(12'h300, rd);
        chk("R10 mpp legal", 32'(rd[12:11]), 32'(ep));
        doRet(MRET);
        chk("R7 valid", 32'(gotV), 32'd1);
        chk("R7 target", gotPc, tgt);
        chk("R7 priv", 32'(gotPriv), 32'(ep));
        csrR(12'h300, rd);
        chk("R7 status", rd, ms(mpie[0], 1'b1, 2'd0, 1'b1, 1'b0, 1'b1));
      end
    end

    // R8 near-miss return words do nothing
    setPriv(2'd1, 1'b0);
    csrW(12'h100, 32'h0000_0122);
    for (int k = 0; k < 32; k++) begin
      if (k != 29) begin
        logic [1:0] pb;
        pb = curPriv;
        csrR(12'h300, rd2);
        doRet(SRET ^ (32'd1 << k));
        chk("R8 no redirect", 32'(gotV), 32'd0);
        chk("R8 priv kept", 32'(gotPriv), 32'(pb));
        csrR(12'h300, rd);
        chk("R8 status kept", rd, rd2);
      end
    end

    // R9 R10 status view and masking
    csrW(12'h300, 32'hFFFF_FFFF);
    csrR(12'h300, rd); chk("R10 mstatus bits", rd, 32'h0000_19AA);
    csrR(12'h100, rd); chk("R9 sstatus view", rd, 32'h0000_0122);
    csrW(12'h100, 32'h0);
    csrR(12'h300, rd); chk("R9 R10 sstatus write", rd, 32'h0000_1888);
    for (int k = 0; k < 32; k++) begin
      csrW(12'h100, 32'd1 << k);
      csrR(12'h300, rd);
      chk("R10 sstatus bit walk", rd, 32'h0000_1888 | ((32'd1 << k) & 32'h122));
      csrR(12'h100, rd);
      chk("R9 sstatus bit walk", rd, (32'd1 << k) & 32'h122);
    end

    // R11 priority: trap over return over CSR write
    setPriv(2'd3, 1'b0);
    csrW(12'h105, 32'h1111_1100);
    csrW(12'h302, 32'hFFFF_FFFF);
    @(negedge clk);
    trapValid = 1'b1; trapIsIrq = 1'b0; trapCause = 5'd3; trapPc = 32'h0000_7770; trapVal = 32'h1;
    retValid = 1'b1; retInsn = SRET;
    csrWe = 1'b1; csrAddr = 12'h105; csrWdata = 32'hFFFF_FFF0;
    @(negedge clk);
    trapValid = 1'b0; retValid = 1'b0; csrWe = 1'b0;
    sample();
    chk("R11 trap wins target", gotPc, MVEC & ~32'd3);
    chk("R11 trap wins priv", 32'(gotPriv), 32'd3);
    csrR(12'h105, rd); chk("R11 write dropped", rd, 32'h1111_1100);
    csrR(12'h341, rd); chk("R11 trap recorded", rd, 32'h0000_7770);
    csrW(12'h141, 32'h0000_ABC4);
    csrW(12'h100, 32'h0000_0100);
    @(negedge clk);
    retValid = 1'b1; retInsn = SRET;
    csrWe = 1'b1; csrAddr = 12'h305; csrWdata = 32'h0;
    @(negedge clk);
    retValid = 1'b0; csrWe = 1'b0;
    sample();
    chk("R11 return wins target", gotPc, 32'h0000_ABC4);
    chk("R11 return wins priv", 32'(gotPriv), 32'd1);
    csrR(12'h305, rd); chk("R11 write dropped", rd, MVEC);

    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  logic [11:0] u_addrs [10] = '{12'h302, 12'h303, 12'h305, 12'h105, 12'h341,
                               12'h141, 12'h342, 12'h142, 12'h343, 12'h143};
endmodule